// File: doc/BRIEF.md
# Display Channel Fault and Timing Interrupt Hub

This block gathers per-channel event pulses from a set of display output channels and merges them into a single interrupt line. Each channel reports three kinds of event: a pixel underflow, an end of frame and an end of line. Every event sets a sticky flag in a status register. A flag stays set until software clears it by writing a one to its bit position.

A control register holds one block-wide enable and, for each channel, a channel interrupt enable plus one enable for each of the three event kinds. While the block-wide enable is clear, no event is recorded. A flag reaches the interrupt line only when both its channel enable and its source enable are set. The interrupt output is a register that is computed from the next-state values of the flags and enables. It therefore moves on the same clock edge as the event or register write that causes the change, and never shows an enable state that has already been written away.

To re-arm a source, software first clears its flag and then sets the enables. A flag that was recorded while the source was masked, and that was cleared before re-enabling, can never raise the line.

Top module: `pixout_irq_hub`

## Requirements
- R1: After reset the control register, every status flag and `irq` are all zero.
- R2: With `reg_sel`=0, a write loads the control register and a read returns it. Bit 0 is the block-wide enable. For channel c, bit 4c+1 is the channel interrupt enable, bit 4c+2 enables underflow, bit 4c+3 enables end of frame and bit 4c+4 enables end of line. Bits above 4·NUM_CH read as zero.
- R3: With `reg_sel`=1, a read returns the status flags. For channel c, bit 3c is underflow, bit 3c+1 is end of frame and bit 3c+2 is end of line. An event pulse sampled on an edge while the block-wide enable is set makes its flag read 1 after that edge, and the flag stays set.
- R4: While the block-wide enable is clear, event pulses set no flag.
- R5: A status write clears exactly the flags whose data bits are 1. Data bits of 0 leave flags unchanged, and a status write does not alter the control register.
- R6: When an event and a clear of the same flag arrive on the same edge, the flag ends up set.
- R7: `irq` is 1 exactly when some flag is set and both its channel enable and its source enable are set. The value is registered and reflects the flag and enable values that result from the same edge.
- R8: If a flag is recorded while its source is masked, then cleared, and then its enables are set, `irq` stays 0.
- R9: Reading either register changes no flag, no enable and not `irq`.
- R10: Flags are recorded whether or not their channel or source enables are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register (combinational) |
| ev_uflow | input | NUM_CH | Per-channel underflow event pulse |
| ev_eof | input | NUM_CH | Per-channel end-of-frame event pulse |
| ev_eol | input | NUM_CH | Per-channel end-of-line event pulse |
| irq | output | 1 | Merged interrupt level |

## Verification
All results are due one clock edge after their stimulus. Flags, control contents and `irq` all change on the edge that samples the event or the write, and register reads return that state combinationally. The driver applies each stimulus on a falling edge and keeps it for one full cycle. When it queues an expected read value and interrupt level, it does so on the falling edge after the edge that takes effect. The monitor pops and compares these items a fixed delay after that falling edge, well away from the next rising edge. This ordering makes the same-edge interrupt behaviour of R7 and R8 directly visible.

// File: rtl/pixirq_pkg.sv
package pixirq_pkg;

   // event kinds carried by every channel, in status-bit order
   typedef enum int unsigned {
      SRC_UFLOW = 0,
      SRC_EOF   = 1,
      SRC_EOL   = 2
   } src_e;

   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_STAT = 1'b1
   } reg_sel_e;

   localparam int unsigned SRCS_PER_CH = 3;
   // per-channel control field: channel enable, then one enable per source
   localparam int unsigned CTRL_FIELDS = SRCS_PER_CH + 1;
   localparam int unsigned CF_CHAN     = 0;
   localparam int unsigned CTRL_BLK    = 0;

   function automatic int unsigned ctrl_pos(int unsigned ch, int unsigned fld);
      return 1 + ch * CTRL_FIELDS + fld;
   endfunction

   function automatic int unsigned flag_pos(int unsigned ch, int unsigned src);
      return ch * SRCS_PER_CH + src;
   endfunction

   function automatic int unsigned ctrl_width(int unsigned nch);
      return 1 + nch * CTRL_FIELDS;
   endfunction

endpackage

// File: rtl/pixirq_ctrl_reg.sv
module pixirq_ctrl_reg
   import pixirq_pkg::*;
#(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned CTRL_W = ctrl_width(NUM_CH),
   localparam int unsigned FLAG_W = NUM_CH * SRCS_PER_CH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [CTRL_W-1:0] ctrl_q_o,
   output logic              blk_en_o,
   output logic [FLAG_W-1:0] gate_q_o,
   output logic [FLAG_W-1:0] gate_d_o
);

   logic [CTRL_W-1:0] ctrl_q;
   logic [CTRL_W-1:0] ctrl_d;

   assign ctrl_d = wr_i ? wdata_i[CTRL_W-1:0] : ctrl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) ctrl_q <= '0;
      else        ctrl_q <= ctrl_d;
   end

   // per-source gate: channel enable AND source enable
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      for (genvar s = 0; s < SRCS_PER_CH; s++) begin : g_src
         localparam int unsigned FP = flag_pos(ch, s);
         localparam int unsigned CP = ctrl_pos(ch, CF_CHAN);
         localparam int unsigned SP = ctrl_pos(ch, 1 + s);
         assign gate_d_o[FP] = ctrl_d[CP] & ctrl_d[SP];
         assign gate_q_o[FP] = ctrl_q[CP] & ctrl_q[SP];
      end
   end

   assign ctrl_q_o = ctrl_q;
   assign blk_en_o = ctrl_q[CTRL_BLK];

   // R2: contents change only through a control write
   a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(ctrl_q));
   // R2: a control write loads the defined bits
   a_r2_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (ctrl_q == $past(wdata_i[CTRL_W-1:0])));

endmodule

// File: rtl/pixirq_flag_bank.sv
module pixirq_flag_bank
   import pixirq_pkg::*;
#(
   parameter int unsigned NUM_CH = 3,
   localparam int unsigned FLAG_W = NUM_CH * SRCS_PER_CH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blk_en_i,
   input  logic [FLAG_W-1:0] ev_i,
   input  logic              clr_i,
   input  logic [FLAG_W-1:0] clr_mask_i,
   output logic [FLAG_W-1:0] flags_q_o,
   output logic [FLAG_W-1:0] flags_d_o
);

   logic [FLAG_W-1:0] flags_q;
   logic [FLAG_W-1:0] flags_d;

   // set has priority over write-one-to-clear
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      for (genvar s = 0; s < SRCS_PER_CH; s++) begin : g_src
         localparam int unsigned FP = flag_pos(ch, s);
         assign flags_d[FP] = (blk_en_i & ev_i[FP]) |
                              (flags_q[FP] & ~(clr_i & clr_mask_i[FP]));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_d;
   end

   assign flags_q_o = flags_q;
   assign flags_d_o = flags_d;

   // R4: no new flag while the block is disabled
   a_r4_no_latch_off: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_en_i |=> ((flags_q & ~$past(flags_q)) == '0));
   // R6: an enabled event always leaves its flag set, clear or not
   a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_en_i && (ev_i != '0)) |=> ((flags_q & $past(ev_i)) == $past(ev_i)));
   // R5: cleared bits drop when no event competes
   a_r5_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !blk_en_i) |=> ((flags_q & $past(clr_mask_i)) == '0));
   // R5: without clear or event, flags hold
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !blk_en_i) |=> $stable(flags_q));

endmodule

// File: rtl/pixirq_irq_merge.sv
module pixirq_irq_merge #(
   parameter int unsigned FLAG_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAG_W-1:0] flags_d_i,
   input  logic [FLAG_W-1:0] gate_d_i,
   input  logic [FLAG_W-1:0] flags_q_i,
   input  logic [FLAG_W-1:0] gate_q_i,
   output logic              irq_o
);

   logic irq_q;

   // computed from next-state values so the line tracks the same edge
   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(flags_d_i & gate_d_i);
   end

   assign irq_o = irq_q;

   // R7, R8: the line always matches the registered flags and gates
   a_r7_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (irq_q == |(flags_q_i & gate_q_i)));

endmodule

// File: rtl/pixout_irq_hub.sv
module pixout_irq_hub
   import pixirq_pkg::*;
#(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NUM_CH-1:0] ev_uflow,
   input  logic [NUM_CH-1:0] ev_eof,
   input  logic [NUM_CH-1:0] ev_eol,
   output logic              irq
);

   localparam int unsigned CTRL_W = ctrl_width(NUM_CH);
   localparam int unsigned FLAG_W = NUM_CH * SRCS_PER_CH;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("pixout_irq_hub: NUM_CH must be at least 1");
   end
   if (DATA_W < CTRL_W) begin : g_bad_ctrl_w
      $error("pixout_irq_hub: DATA_W too narrow for control register");
   end
   if (DATA_W < FLAG_W) begin : g_bad_stat_w
      $error("pixout_irq_hub: DATA_W too narrow for status register");
   end

   logic [FLAG_W-1:0] ev_vec;
   logic [CTRL_W-1:0] ctrl_q;
   logic              blk_en;
   logic [FLAG_W-1:0] gate_q;
   logic [FLAG_W-1:0] gate_d;
   logic [FLAG_W-1:0] flags_q;
   logic [FLAG_W-1:0] flags_d;
   logic              ctrl_wr;
   logic              stat_clr;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_pack
      assign ev_vec[flag_pos(ch, SRC_UFLOW)] = ev_uflow[ch];
      assign ev_vec[flag_pos(ch, SRC_EOF)]   = ev_eof[ch];
      assign ev_vec[flag_pos(ch, SRC_EOL)]   = ev_eol[ch];
   end

   assign ctrl_wr  = reg_wr & (reg_sel == SEL_CTRL);
   assign stat_clr = reg_wr & (reg_sel == SEL_STAT);

   pixirq_ctrl_reg #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (ctrl_wr),
      .wdata_i  (reg_wdata),
      .ctrl_q_o (ctrl_q),
      .blk_en_o (blk_en),
      .gate_q_o (gate_q),
      .gate_d_o (gate_d)
   );

   pixirq_flag_bank #(.NUM_CH(NUM_CH)) i_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .blk_en_i   (blk_en),
      .ev_i       (ev_vec),
      .clr_i      (stat_clr),
      .clr_mask_i (reg_wdata[FLAG_W-1:0]),
      .flags_q_o  (flags_q),
      .flags_d_o  (flags_d)
   );

   pixirq_irq_merge #(.FLAG_W(FLAG_W)) i_merge (
      .clk       (clk),
      .rst_n     (rst_n),
      .flags_d_i (flags_d),
      .gate_d_i  (gate_d),
      .flags_q_i (flags_q),
      .gate_q_i  (gate_q),
      .irq_o     (irq)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_sel == SEL_STAT) reg_rdata[FLAG_W-1:0] = flags_q;
      else                     reg_rdata[CTRL_W-1:0] = ctrl_q;
   end

   // R9: with no write, a read leaves the control register untouched
   a_r9_read_pure: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> $stable(ctrl_q));

endmodule

// File: tb/test_pixout_irq_hub.sv
`timescale 1ns/1ps
module test_pixout_irq_hub;

   localparam int NCH = 3;
   localparam int DW  = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic          reg_sel = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [NCH-1:0] ev_uflow = '0;
   logic [NCH-1:0] ev_eof = '0;
   logic [NCH-1:0] ev_eol = '0;
   logic          irq;

   always #2.5 clk = ~clk;

   pixout_irq_hub #(.NUM_CH(NCH), .DATA_W(DW)) i_pixout_irq_hub (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_uflow(ev_uflow),
      .ev_eof(ev_eof), .ev_eol(ev_eol), .irq(irq)
   );

   typedef struct packed {
      logic          sel;
      logic [DW-1:0] rd;
      logic          irq;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    n_checks = 0;
   int    n_fails = 0;
   bit    finished = 0;

   // bit positions taken from R2 and R3
   function automatic logic [DW-1:0] cbit(int ch, int fld);
      return DW'(1) << (1 + 4 * ch + fld);
   endfunction
   function automatic logic [DW-1:0] sbit(int ch, int src);
      return DW'(1) << (3 * ch + src);
   endfunction
   localparam logic [DW-1:0] BLK = 1;

   // monitor: compares queued items shortly after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (reg_rdata !== e.rd || irq !== e.irq) begin
               n_fails++;
               $display("FAIL %s: sel=%0d rdata=%h irq=%b expected rdata=%h irq=%b",
                        t, e.sel, reg_rdata, irq, e.rd, e.irq);
            end
         end
      end
   end

   task automatic idle();
      reg_wr = 0; ev_uflow = '0; ev_eof = '0; ev_eol = '0;
      @(negedge clk);
   endtask

   task automatic wr(input logic sel, input logic [DW-1:0] d);
      reg_wr = 1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic pulse(input logic [NCH-1:0] uf, input logic [NCH-1:0] fr,
                        input logic [NCH-1:0] ln, input logic clr,
                        input logic [DW-1:0] mask);
      ev_uflow = uf; ev_eof = fr; ev_eol = ln;
      reg_wr = clr; reg_sel = 1'b1; reg_wdata = mask;
      @(negedge clk);
      ev_uflow = '0; ev_eof = '0; ev_eol = '0; reg_wr = 0;
   endtask

   task automatic chk(input logic sel, input logic [DW-1:0] rd,
                      input logic ir, input string t);
      exp_t e;
      reg_wr = 0; reg_sel = sel;
      e.sel = sel; e.rd = rd; e.irq = ir;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      chk(0, '0, 0, "R1 control after reset");
      chk(1, '0, 0, "R1 status after reset");
      // R2: block enable only
      wr(0, BLK);
      chk(0, BLK, 0, "R2 control readback");
      // R3, R10: underflow on channel 1 with sources masked
      pulse(3'b010, '0, '0, 0, '0);
      chk(1, sbit(1, 0), 0, "R3 R10 flag latched while masked");
      chk(1, sbit(1, 0), 0, "R9 second read unchanged");
      chk(0, BLK, 0, "R9 control unchanged by reads");
      // R7: enabling raises irq on the write edge
      wr(0, BLK | cbit(1, 0) | cbit(1, 1));
      chk(0, BLK | cbit(1, 0) | cbit(1, 1), 1, "R7 irq on enable");
      // R5: writing zeros clears nothing
      wr(1, '0);
      chk(1, sbit(1, 0), 1, "R5 zero write keeps flag");
      chk(0, BLK | cbit(1, 0) | cbit(1, 1), 1, "R5 status write keeps control");
      wr(1, sbit(1, 0));
      chk(1, '0, 0, "R5 R7 clear drops flag and irq");
      // R8: masked latch, clear, then re-enable
      wr(0, BLK);
      pulse(3'b010, '0, '0, 0, '0);
      chk(1, sbit(1, 0), 0, "R8 masked latch no irq");
      wr(1, sbit(1, 0));
      wr(0, BLK | cbit(1, 0) | cbit(1, 1));
      chk(1, '0, 0, "R8 re-enable after clear stays quiet");
      // R6: event and clear on the same edge
      pulse(3'b100, '0, '0, 1, sbit(2, 0));
      chk(1, sbit(2, 0), 0, "R6 event beats clear");
      // R4: block disabled ignores all events
      wr(0, cbit(1, 0) | cbit(1, 1));
      pulse('1, '1, '1, 0, '0);
      chk(1, sbit(2, 0), 0, "R4 events ignored while disabled");
      // R7: source enable without channel enable stays low
      wr(0, BLK | cbit(2, 1));
      chk(0, BLK | cbit(2, 1), 0, "R7 channel enable required");
      wr(0, BLK | cbit(2, 0) | cbit(2, 1));
      chk(1, sbit(2, 0), 1, "R7 both enables raise irq");
      // R3, R7: end-of-frame and end-of-line sources
      wr(1, 32'h1FF);
      chk(1, '0, 0, "R5 clear all flags");
      wr(0, BLK | cbit(0, 0) | cbit(0, 3));
      pulse('0, 3'b001, 3'b001, 0, '0);
      chk(1, sbit(0, 1) | sbit(0, 2), 1, "R3 R7 frame and line flags");
      wr(1, sbit(0, 2));
      chk(1, sbit(0, 1), 0, "R5 R7 line clear drops irq");
      // R2: unused control bits read zero
      wr(0, '1);
      chk(0, 32'h1FFF, 1, "R2 unused bits zero, R7 frame enabled");
      idle();
      idle();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule